// File: doc/BRIEF.md
# Vector Register Gather Unit

This unit performs a masked gather over a vector register group. For every active destination element it obtains an index. The index comes either from a per-element index store or from one scalar value shared by all elements. The unit then reads the source element at that index and writes it to the destination element. An index that falls outside the source group writes zero. Elements whose mask bit is clear are not written, so the destination keeps its old value.

An operation is launched with a single-cycle `start`. The configuration and mask are captured at that moment. Before any element is processed, the unit checks the configuration: the element width, whether the destination group is large enough, and the index grouping ratio. A bad configuration raises a sticky exception flag and writes nothing. Otherwise the unit walks the elements from the start element up to the vector length, one per clock, and finishes with a `done` pulse. On a normal finish it also pulses a request to clear the start element. The source and index stores sit outside the unit and answer their read addresses combinationally.

Top module: `vgather_unit`

## Requirements
- R1: `cfg_ew_bytes` gives the element width in bytes; only 1, 2, 4 and 8 are legal. Any other value sets `exc_flag` and pulses `done` one cycle after `start`, with no write.
- R2: In vector-index mode (`scalar_mode`=0, `idx16_mode`=0), element i takes as its index the low 8·ew bits of index word i. It writes the low 8·ew bits of the source word at that index (upper bits zero) to `wr_idx`=i.
- R3: With `idx16_mode`=1 and `scalar_mode`=0, the index is bits [15:0] of index word i, whatever the element width. Data still uses the element width.
- R4: An index greater than or equal to `cfg_src_regs`·(`cfg_reg_bytes`/ew) writes zero.
- R5: With `scalar_mode`=1, every element uses the 32-bit `scalar_index` as its index.
- R6: Mask bit for element i is bit (i mod 8) of mask byte (i div 8), which is bit i of `mask`. A clear bit gives no write for that element, and its cycle still passes.
- R7: Elements are visited from `cfg_start_elem` to `cfg_vl`−1. Completion pulses `start_clr` together with `done`. If `cfg_start_elem` ≥ `cfg_vl`, the unit does no writes and pulses `done` and `start_clr` one cycle after `start`.
- R8: If `cfg_dst_regs` is less than max(1, ceil(`cfg_vl`/(`cfg_reg_bytes`/ew))), the unit raises the exception with no writes.
- R9: If floor(`cfg_lmul`·iw/ew) exceeds 64, the unit raises the exception. Here iw is 2 bytes in 16-bit index mode and ew otherwise; a ratio of exactly 64 is legal.
- R10: The element visited first appears on the write port one cycle after `start`. Each later element follows one cycle after the one before it. A single-cycle `done` follows one cycle after the last element.
- R11: `exc_flag` stays set until `exc_clr` is pulsed. While it is set, `start` is ignored: no write and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse; configuration and mask captured here |
| exc_clr | input | 1 | Clears the sticky exception flag |
| cfg_ew_bytes | input | 4 | Element width in bytes |
| cfg_vl | input | VL_W | Vector length in elements |
| cfg_start_elem | input | VL_W | First element to process |
| cfg_reg_bytes | input | RB_W | Bytes per vector register |
| cfg_lmul | input | LMUL_W | Register grouping multiplier |
| cfg_src_regs | input | REG_W | Registers in the source group |
| cfg_dst_regs | input | REG_W | Registers in the destination group |
| idx16_mode | input | 1 | Indices are 16 bits wide |
| scalar_mode | input | 1 | One scalar index for all elements |
| scalar_index | input | 32 | Scalar index value |
| mask | input | MAX_VL | Element mask, bit i for element i |
| idx_addr | output | VL_W | Index store read address |
| idx_data | input | 64 | Index store read data |
| src_addr | output | SRC_AW | Source store read address |
| src_data | input | 64 | Source store read data |
| wr_en | output | 1 | Destination element write enable |
| wr_idx | output | VL_W | Destination element number |
| wr_data | output | 64 | Destination element value |
| done | output | 1 | Completion pulse |
| start_clr | output | 1 | Request to clear the start element |
| exc_flag | output | 1 | Sticky exception flag |

## Verification
The bench builds the unit with its default parameters: a 64-element mask, 8-bit register byte count, 4-bit register counts and a 12-bit source address. With 16-byte registers this covers all four element widths. It also covers a group large enough that 16-bit indices reach past the source range while their truncated form would not. Lengths up to 40 elements with a nonzero start, the grouping ratio just at and just over 64, and a destination group one register short all fit within these values.

// File: rtl/gather_pkg.sv
// Shared types and helpers for the vector gather unit.
// Assumes element data words are at most 64 bits wide.
package gather_pkg;

    localparam int ELEM_BITS = 64;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gather_state_t;

    // True for the four supported element widths in bytes.
    function automatic logic ew_legal(input logic [3:0] ew);
        return (ew == 4'd1) || (ew == 4'd2) || (ew == 4'd4) || (ew == 4'd8);
    endfunction

    // log2 of a legal element width; 0 for illegal codes.
    function automatic logic [1:0] ew_shift(input logic [3:0] ew);
        case (ew)
            4'd2:    return 2'd1;
            4'd4:    return 2'd2;
            4'd8:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // Keep only the low 8*ew bits of a word.
    function automatic logic [ELEM_BITS-1:0] trunc_ew(input logic [ELEM_BITS-1:0] d,
                                                      input logic [3:0] ew);
        case (ew)
            4'd1:    return {56'd0, d[7:0]};
            4'd2:    return {48'd0, d[15:0]};
            4'd4:    return {32'd0, d[31:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/gather_cfg_check.sv
// Configuration legality check for the gather unit.
// Combinational; evaluated on the live configuration in the launch cycle.
// Assumes cfg_reg_bytes is a multiple of the element width.
module gather_cfg_check
    import gather_pkg::*;
#(
    parameter int VL_W   = 7,
    parameter int RB_W   = 8,
    parameter int REG_W  = 4,
    parameter int LMUL_W = 8,
    localparam int CNT_W = RB_W + REG_W
) (
    input  logic [3:0]        ew_bytes,
    input  logic              idx16,
    input  logic [VL_W-1:0]   vl,
    input  logic [RB_W-1:0]   reg_bytes,
    input  logic [LMUL_W-1:0] lmul,
    input  logic [REG_W-1:0]  src_regs,
    input  logic [REG_W-1:0]  dst_regs,
    output logic              cfg_err,
    output logic [CNT_W-1:0]  max_index
);

    logic [RB_W-1:0]  elems_per_reg;
    logic [CNT_W-1:0] dst_cap;
    logic [31:0]      grp_lhs;
    logic [31:0]      grp_rhs;
    logic             width_bad;
    logic             dst_bad;
    logic             grp_bad;

    // Derive per-register element count, capacities and the three error terms.
    always_comb begin
        elems_per_reg = reg_bytes >> ew_shift(ew_bytes);
        dst_cap       = CNT_W'(dst_regs) * CNT_W'(elems_per_reg);
        max_index     = CNT_W'(src_regs) * CNT_W'(elems_per_reg);
        grp_lhs       = 32'(lmul) * (idx16 ? 32'd2 : 32'(ew_bytes));
        grp_rhs       = 32'd65 * 32'(ew_bytes);
        width_bad     = !ew_legal(ew_bytes);
        dst_bad       = (dst_regs == '0) || (32'(dst_cap) < 32'(vl));
        grp_bad       = (grp_lhs >= grp_rhs);
        cfg_err       = width_bad || dst_bad || grp_bad;
    end

endmodule

// File: rtl/gather_elem_path.sv
// Per-element datapath: index selection, range test and result formatting.
// Combinational; the source store answers src_addr in the same cycle.
module gather_elem_path
    import gather_pkg::*;
#(
    parameter int SRC_AW = 12,
    parameter int CNT_W  = 12
) (
    input  logic [3:0]           ew_bytes,
    input  logic                 idx16,
    input  logic                 scalar_sel,
    input  logic [31:0]          scalar_idx,
    input  logic [ELEM_BITS-1:0] idx_word,
    input  logic [ELEM_BITS-1:0] src_word,
    input  logic [CNT_W-1:0]     max_index,
    output logic [SRC_AW-1:0]    src_addr,
    output logic [ELEM_BITS-1:0] elem_val,
    output logic                 oob
);

    logic [ELEM_BITS-1:0] eff_idx;

    // Choose the index source, test it against the group size, shape the result.
    always_comb begin
        if (scalar_sel)
            eff_idx = {32'd0, scalar_idx};
        else if (idx16)
            eff_idx = {48'd0, idx_word[15:0]};
        else
            eff_idx = trunc_ew(idx_word, ew_bytes);
        oob      = eff_idx >= ELEM_BITS'(max_index);
        src_addr = eff_idx[SRC_AW-1:0];
        elem_val = oob ? '0 : trunc_ew(src_word, ew_bytes);
    end

endmodule

// File: rtl/vgather_unit.sv
// Vector register gather unit, one element per clock.
// Captures configuration and mask on start, checks legality, then walks
// elements start..vl-1 writing gathered values under the mask.
// Assumes combinational read stores and that start is a single-cycle pulse.
module vgather_unit
    import gather_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int RB_W   = 8,
    parameter int REG_W  = 4,
    parameter int LMUL_W = 8,
    parameter int SRC_AW = 12,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int EI_W  = $clog2(MAX_VL),
    localparam int CNT_W = RB_W + REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 exc_clr,
    input  logic [3:0]           cfg_ew_bytes,
    input  logic [VL_W-1:0]      cfg_vl,
    input  logic [VL_W-1:0]      cfg_start_elem,
    input  logic [RB_W-1:0]      cfg_reg_bytes,
    input  logic [LMUL_W-1:0]    cfg_lmul,
    input  logic [REG_W-1:0]     cfg_src_regs,
    input  logic [REG_W-1:0]     cfg_dst_regs,
    input  logic                 idx16_mode,
    input  logic                 scalar_mode,
    input  logic [31:0]          scalar_index,
    input  logic [MAX_VL-1:0]    mask,
    output logic [VL_W-1:0]      idx_addr,
    input  logic [ELEM_BITS-1:0] idx_data,
    output logic [SRC_AW-1:0]    src_addr,
    input  logic [ELEM_BITS-1:0] src_data,
    output logic                 wr_en,
    output logic [VL_W-1:0]      wr_idx,
    output logic [ELEM_BITS-1:0] wr_data,
    output logic                 done,
    output logic                 start_clr,
    output logic                 exc_flag
);

    gather_state_t      state;
    logic [VL_W-1:0]    cur;
    logic [VL_W-1:0]    vl_q;
    logic [VL_W-1:0]    st_q;
    logic [MAX_VL-1:0]  mask_q;
    logic [3:0]         ew_q;
    logic               idx16_q;
    logic               scalar_q;
    logic [31:0]        sidx_q;
    logic [CNT_W-1:0]   maxi_q;
    logic               done_q;
    logic               clr_q;
    logic               exc_q;
    logic               cfg_err;
    logic [CNT_W-1:0]   max_index;
    logic               oob;
    logic [ELEM_BITS-1:0] elem_val;

    gather_cfg_check #(
        .VL_W   (VL_W),
        .RB_W   (RB_W),
        .REG_W  (REG_W),
        .LMUL_W (LMUL_W)
    ) u_cfg (
        .ew_bytes  (cfg_ew_bytes),
        .idx16     (idx16_mode),
        .vl        (cfg_vl),
        .reg_bytes (cfg_reg_bytes),
        .lmul      (cfg_lmul),
        .src_regs  (cfg_src_regs),
        .dst_regs  (cfg_dst_regs),
        .cfg_err   (cfg_err),
        .max_index (max_index)
    );

    gather_elem_path #(
        .SRC_AW (SRC_AW),
        .CNT_W  (CNT_W)
    ) u_path (
        .ew_bytes   (ew_q),
        .idx16      (idx16_q),
        .scalar_sel (scalar_q),
        .scalar_idx (sidx_q),
        .idx_word   (idx_data),
        .src_word   (src_data),
        .max_index  (maxi_q),
        .src_addr   (src_addr),
        .elem_val   (elem_val),
        .oob        (oob)
    );

    // Sequencer: launch, legality outcome, element walk and sticky exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur      <= '0;
            vl_q     <= '0;
            st_q     <= '0;
            mask_q   <= '0;
            ew_q     <= 4'd1;
            idx16_q  <= 1'b0;
            scalar_q <= 1'b0;
            sidx_q   <= '0;
            maxi_q   <= '0;
            done_q   <= 1'b0;
            clr_q    <= 1'b0;
            exc_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            clr_q  <= 1'b0;
            if (exc_clr)
                exc_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && !exc_q) begin
                        vl_q     <= cfg_vl;
                        st_q     <= cfg_start_elem;
                        mask_q   <= mask;
                        ew_q     <= cfg_ew_bytes;
                        idx16_q  <= idx16_mode;
                        scalar_q <= scalar_mode;
                        sidx_q   <= scalar_index;
                        maxi_q   <= max_index;
                        if (cfg_err) begin
                            exc_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else if (cfg_start_elem >= cfg_vl) begin
                            done_q <= 1'b1;
                            clr_q  <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                            cur   <= cfg_start_elem;
                        end
                    end
                end
                ST_RUN: begin
                    if (cur == VL_W'(vl_q - 1'b1)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        clr_q  <= 1'b1;
                    end else begin
                        cur <= cur + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the store addresses and the element write port.
    always_comb begin
        idx_addr  = cur;
        wr_idx    = cur;
        wr_en     = (state == ST_RUN) && mask_q[cur[EI_W-1:0]];
        wr_data   = elem_val;
        done      = done_q;
        start_clr = clr_q;
        exc_flag  = exc_q;
    end

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state == ST_IDLE));

    assert_step_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN) |-> (cur == $past(cur) + 1'b1));

    assert_wr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cur < vl_q && cur >= st_q));

    assert_oob_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && oob) |-> (wr_data == '0));

    assert_clr_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> (done_q && !exc_q));

    assert_exc_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_q && !exc_clr) |=> exc_q);

    assert_exc_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |-> (state == ST_IDLE && !wr_en));

    assert_legal_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ew_legal(ew_q));

endmodule

// File: tb/sim_vgather_unit.sv
// Bench for vgather_unit: a behavioural reference model builds the expected
// per-cycle port values for each operation into a queue and every clock is
// compared against it.
module sim_vgather_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL = 64;
    localparam int VL_W   = 7;
    localparam int RB_W   = 8;
    localparam int REG_W  = 4;
    localparam int LMUL_W = 8;
    localparam int SRC_AW = 12;

    logic clk = 1'b0;
    logic rst_n, start, exc_clr, idx16_mode, scalar_mode;
    logic [3:0]        cfg_ew_bytes;
    logic [VL_W-1:0]   cfg_vl, cfg_start_elem;
    logic [RB_W-1:0]   cfg_reg_bytes;
    logic [LMUL_W-1:0] cfg_lmul;
    logic [REG_W-1:0]  cfg_src_regs, cfg_dst_regs;
    logic [31:0]       scalar_index;
    logic [MAX_VL-1:0] mask;
    logic [VL_W-1:0]   idx_addr, wr_idx;
    logic [SRC_AW-1:0] src_addr;
    logic [63:0]       idx_data, src_data, wr_data;
    logic wr_en, done, start_clr, exc_flag;

    logic [63:0] src_mem [256];
    logic [63:0] idx_mem [64];

    assign src_data = src_mem[src_addr[7:0]];
    assign idx_data = idx_mem[idx_addr[5:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    vgather_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .exc_clr(exc_clr),
        .cfg_ew_bytes(cfg_ew_bytes), .cfg_vl(cfg_vl), .cfg_start_elem(cfg_start_elem),
        .cfg_reg_bytes(cfg_reg_bytes), .cfg_lmul(cfg_lmul),
        .cfg_src_regs(cfg_src_regs), .cfg_dst_regs(cfg_dst_regs),
        .idx16_mode(idx16_mode), .scalar_mode(scalar_mode), .scalar_index(scalar_index),
        .mask(mask), .idx_addr(idx_addr), .idx_data(idx_data),
        .src_addr(src_addr), .src_data(src_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .start_clr(start_clr), .exc_flag(exc_flag)
    );

    typedef struct {
        bit          we;
        int          idx;
        logic [63:0] data;
        bit          dn;
        bit          clr;
        bit          ex;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   model_exc = 1'b0;

    function automatic logic [63:0] ewmask(input int ew);
        if (ew >= 8) return '1;
        return (64'd1 << (8 * ew)) - 64'd1;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic compare(input exp_t e);
        check_eq(e.req, "wr_en", 64'(wr_en), 64'(e.we));
        if (e.we) begin
            check_eq(e.req, "wr_idx", 64'(wr_idx), 64'(e.idx));
            check_eq(e.req, "wr_data", wr_data, e.data);
        end
        check_eq(e.req, "done", 64'(done), 64'(e.dn));
        check_eq(e.req, "start_clr", 64'(start_clr), 64'(e.clr));
        check_eq(e.req, "exc_flag", 64'(exc_flag), 64'(e.ex));
    endtask

    // Reference model plus stimulus for one launch.
    task automatic run_op(input int ew, input int vl, input int st, input int rb,
                          input int lmul, input int sregs, input int dregs,
                          input bit i16, input bit sc, input logic [31:0] sidx,
                          input logic [63:0] msk, input string req);
        exp_t e;
        bit   legal, err;
        int   epr, need, idxw, maxi;
        logic [63:0] idx;
        if (model_exc) begin
            e = '{0, 0, 64'd0, 0, 0, 1, req};
            q.push_back(e);
        end else begin
            legal = (ew == 1) || (ew == 2) || (ew == 4) || (ew == 8);
            err = !legal;
            epr = 0; maxi = 0;
            if (legal) begin
                epr  = rb / ew;
                need = (vl + epr - 1) / epr;
                if (need < 1) need = 1;
                idxw = i16 ? 2 : ew;
                if ((lmul * idxw) / ew > 64) err = 1'b1;
                if (dregs < need) err = 1'b1;
                maxi = sregs * epr;
            end
            if (err) begin
                e = '{0, 0, 64'd0, 1, 0, 1, req};
                q.push_back(e);
                model_exc = 1'b1;
            end else begin
                for (int i = st; i < vl; i++) begin
                    if (sc)       idx = {32'd0, sidx};
                    else if (i16) idx = idx_mem[i] & 64'hFFFF;
                    else          idx = idx_mem[i] & ewmask(ew);
                    e.we   = msk[i];
                    e.idx  = i;
                    e.data = (idx >= 64'(maxi)) ? 64'd0 : (src_mem[idx[7:0]] & ewmask(ew));
                    e.dn = 0; e.clr = 0; e.ex = 0; e.req = req;
                    q.push_back(e);
                end
                e = '{0, 0, 64'd0, 1, 1, 0, req};
                q.push_back(e);
            end
        end
        @(negedge clk);
        cfg_ew_bytes   = 4'(ew);
        cfg_vl         = VL_W'(vl);
        cfg_start_elem = VL_W'(st);
        cfg_reg_bytes  = RB_W'(rb);
        cfg_lmul       = LMUL_W'(lmul);
        cfg_src_regs   = REG_W'(sregs);
        cfg_dst_regs   = REG_W'(dregs);
        idx16_mode     = i16;
        scalar_mode    = sc;
        scalar_index   = sidx;
        mask           = msk;
        start          = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() > 0) begin
            e = q.pop_front();
            compare(e);
            @(negedge clk);
        end
        e = '{0, 0, 64'd0, 0, 0, model_exc, {req, " idle"}};
        compare(e);
    endtask

    task automatic clear_exc();
        @(negedge clk);
        exc_clr = 1'b1;
        @(negedge clk);
        exc_clr = 1'b0;
        model_exc = 1'b0;
        check_eq("R11", "exc_flag after clear", 64'(exc_flag), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++)
            src_mem[k] = 64'hA5C3_0000_0000_0000 ^ (64'(k) * 64'h0101_0101_0101_0101);
        for (int k = 0; k < 64; k++)
            idx_mem[k] = 64'hFFFF_0000_0000_0000 | 64'((k * 5) % 37);
        rst_n = 1'b0; start = 1'b0; exc_clr = 1'b0; idx16_mode = 1'b0; scalar_mode = 1'b0;
        cfg_ew_bytes = 4'd1; cfg_vl = '0; cfg_start_elem = '0; cfg_reg_bytes = '0;
        cfg_lmul = '0; cfg_src_regs = '0; cfg_dst_regs = '0; scalar_index = '0; mask = '0;
        repeat (3) @(negedge clk);
        check_eq("R10", "reset done", 64'(done), 64'd0);
        check_eq("R10", "reset wr_en", 64'(wr_en), 64'd0);
        check_eq("R11", "reset exc_flag", 64'(exc_flag), 64'd0);
        rst_n = 1'b1;

        // R2 R4: 64-bit elements, some indices past the 8-element group
        for (int k = 0; k < 8; k++) idx_mem[k] = 64'((k * 3) % 10);
        run_op(8, 8, 0, 16, 1, 4, 4, 0, 0, 32'd0, '1, "R2");

        // R6: byte elements, alternating mask, truncated indices
        for (int k = 0; k < 64; k++)
            idx_mem[k] = 64'hFFFF_0000_0000_0000 | 64'((k * 5) % 37);
        run_op(1, 20, 0, 16, 1, 2, 2, 0, 0, 32'd0, 64'h5555_5555_5555_5555, "R6");

        // R3: 16-bit indices with byte data
        for (int k = 0; k < 64; k++)
            idx_mem[k] = 64'h1234_0000_0000_0000 | ((k % 2) ? 64'(16'h0100 + k) : 64'(k * 7));
        run_op(1, 16, 0, 16, 1, 15, 1, 1, 0, 32'd0, '1, "R3");
        run_op(1, 16, 0, 16, 1, 15, 1, 0, 0, 32'd0, '1, "R2");

        // R5 R7: scalar index with nonzero start element
        run_op(4, 6, 2, 16, 1, 4, 2, 0, 1, 32'd3, '1, "R5");
        // R4: scalar index beyond the source group
        run_op(4, 6, 2, 16, 1, 4, 2, 0, 1, 32'd1000, '1, "R4");
        // R7: start element at vector length
        run_op(2, 5, 5, 16, 1, 1, 1, 0, 0, 32'd0, '1, "R7");

        // R1 then R11: illegal width, blocked launch, clear
        run_op(3, 4, 0, 16, 1, 1, 1, 0, 0, 32'd0, '1, "R1");
        run_op(2, 4, 0, 16, 1, 1, 1, 0, 0, 32'd0, '1, "R11");
        clear_exc();

        // R8: destination group one register short
        run_op(4, 20, 0, 16, 1, 4, 4, 0, 0, 32'd0, '1, "R8");
        clear_exc();

        // R9: grouping ratio just over and exactly at the limit
        run_op(1, 4, 0, 16, 33, 1, 1, 1, 0, 32'd0, '1, "R9");
        clear_exc();
        run_op(1, 4, 0, 16, 32, 1, 1, 1, 0, 32'd0, '1, "R9");

        // R2 R10: halfword elements, long run, sparse mask, start 3
        for (int k = 0; k < 64; k++)
            idx_mem[k] = 64'hABCD_0000 | 64'((k * 11) % 70);
        run_op(2, 40, 3, 16, 1, 8, 5, 0, 0, 32'd0, 64'hF0F0_F0F0_F0F0_F0F0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule